// File: doc/BRIEF.md
# Lockable System Options Register with Watchdog and STOP Trap

This block holds one byte of system configuration that software may set exactly once after every reset. Three of its bits steer a computer-operating-properly watchdog: whether the watchdog runs, which of two timeout lengths applies, and whether a STOP request is allowed or trapped as an illegal operation. Two further bits choose, for two shared pins, between their special function and a plain output-only port bit.

The watchdog counts bus clock cycles and must be serviced by a strobe before the selected limit is reached. When it runs out, or when a STOP is requested while stop mode is disallowed, the block emits a one-cycle system reset request with a 2-bit cause code. The block also returns itself to its reset state on that request. Reads are combinational and reflect the live register. The address decode happens outside the block, which sees only a write strobe.

Top module: `sysopt_wdog_top`

## Requirements
- R1: After reset the read value is 0xD3. Bit 7 (watchdog enable) is 1, bit 6 (long timeout) is 1, bit 5 (stop allowed) is 0, bit 4 reads 1, bits 3 and 2 read 0, and bits 1 and 0 (pin special functions) are 1.
- R2: The first write after any reset loads bits 7, 6, 5, 1 and 0 from the write data in one cycle and locks the register. Every later write leaves the read value unchanged until the next reset. Write data on bits 4, 3 and 2 has no effect.
- R3: With bit 7 at 1, the watchdog requests a reset 2^LONG_LOG2 cycles after its last clear if bit 6 is 1, or 2^SHORT_LOG2 cycles after it if bit 6 is 0. The defaults are 20 and 18.
- R4: A service strobe clears the watchdog count. A strobe in the last cycle before expiry prevents the timeout.
- R5: A write that changes bit 6 restarts the count from zero. A write that keeps bit 6 leaves the count running.
- R6: With bit 7 at 0, the watchdog never requests a reset.
- R7: A STOP request while bit 5 is 0 gives a reset request with cause 2'b10 on the next cycle. While bit 5 is 1 it gives a one-cycle stop grant on the next cycle and no reset.
- R8: A reset request lasts one cycle and carries cause 2'b01 for a watchdog timeout. Cause 2'b01 wins when a timeout and an illegal STOP coincide. The cause reads 2'b00 whenever no request is present. No new request is raised in the cycle of a request.
- R9: A reset request returns the register to 0xD3, unlocks it and clears the watchdog count, whatever the cause.
- R10: The debug-pin function output follows bit 1 and the reset-pin function output follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Address-decoded register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data (combinational) |
| wdog_kick_i | input | 1 | Watchdog service strobe |
| stop_req_i | input | 1 | STOP request from the processor |
| stop_grant_o | output | 1 | One-cycle permission to enter stop |
| sys_rst_o | output | 1 | One-cycle system reset request |
| rst_cause_o | output | 2 | Cause of the reset request: 01 timeout, 10 illegal STOP |
| dbg_pin_fn_o | output | 1 | 1 selects the debug function for the shared debug pin |
| rst_pin_fn_o | output | 1 | 1 selects the reset function for the shared reset pin |

## Verification
The bench services the watchdog in the exact cycle before expiry. A design that compared against the limit one cycle early or late would reset there or would miss the next deadline. It rewrites the timeout select with an unchanged value before locking, which catches a design that restarts the count on any write, and it writes again after the lock, which catches a lock that does not hold. It raises an illegal STOP in the same cycle as a timeout to pin down the cause priority. After each reset request it reads the register back to prove that the pins and the lock return to their defaults.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;

   localparam int OPT_W          = 8;
   // bit positions software decodes
   localparam int BIT_WDOG_EN    = 7;
   localparam int BIT_LONG_SEL   = 6;
   localparam int BIT_STOP_EN    = 5;
   localparam int BIT_DBG_FN     = 1;
   localparam int BIT_RST_FN     = 0;

   localparam logic [OPT_W-1:0] OPT_RESET = 8'hD3;
   localparam logic [OPT_W-1:0] OPT_WMASK = 8'hE3;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'b00,
      CAUSE_WDOG = 2'b01,
      CAUSE_STOP = 2'b10
   } rst_cause_e;

endpackage

// File: rtl/sysopt_optreg.sv
module sysopt_optreg #(
   parameter int                REG_W   = 8,
   parameter logic [REG_W-1:0]  RST_VAL = 8'hD3,
   parameter logic [REG_W-1:0]  WR_MASK = 8'hE3,
   parameter int                SEL_BIT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr_i,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] val_o,
   output logic             sel_restart_o
);

   initial begin
      assert (SEL_BIT >= 0 && SEL_BIT < REG_W)
         else $error("sysopt_optreg: SEL_BIT outside register");
      assert (WR_MASK[SEL_BIT])
         else $error("sysopt_optreg: SEL_BIT must be writable");
   end

   logic locked_q;
   logic accept;

   assign accept = wr_en_i && !locked_q;

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (WR_MASK[b]) begin : g_rw
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q <= RST_VAL[b];
            else if (soft_clr_i) q <= RST_VAL[b];
            else if (accept)     q <= wr_data_i[b];
         end
         assign val_o[b] = q;
      end else begin : g_fixed
         assign val_o[b] = RST_VAL[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          locked_q <= 1'b0;
      else if (soft_clr_i) locked_q <= 1'b0;
      else if (accept)     locked_q <= 1'b1;
   end

   assign sel_restart_o = accept && (wr_data_i[SEL_BIT] != val_o[SEL_BIT]);

   // R2
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q && !soft_clr_i |=> $stable(val_o));

   // R2
   first_write_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && !soft_clr_i |=> locked_q);

   // R9
   soft_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr_i |=> (val_o == RST_VAL) && !locked_q);

endmodule

// File: rtl/sysopt_wdog_cnt.sv
module sysopt_wdog_cnt #(
   parameter int SHORT_LOG2 = 18,
   parameter int LONG_LOG2  = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic long_sel_i,
   input  logic kick_i,
   input  logic restart_i,
   input  logic clr_i,
   output logic expire_o
);

   localparam int CNT_W = LONG_LOG2;
   localparam logic [CNT_W-1:0] LAST_LONG  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'((64'd1 << SHORT_LOG2) - 64'd1);

   initial begin
      assert (SHORT_LOG2 >= 1)
         else $error("sysopt_wdog_cnt: SHORT_LOG2 must be at least 1");
      assert (LONG_LOG2 >= SHORT_LOG2 && LONG_LOG2 <= 32)
         else $error("sysopt_wdog_cnt: LONG_LOG2 out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;

   if (SHORT_LOG2 == LONG_LOG2) begin : g_single_limit
      logic unused_sel;
      assign unused_sel = long_sel_i;
      assign last_val   = LAST_LONG;
   end else begin : g_dual_limit
      assign last_val = long_sel_i ? LAST_LONG : LAST_SHORT;
   end

   assign expire_o = en_i && !kick_i && !restart_i && (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i || kick_i || restart_i || !en_i || (cnt_q == last_val))
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= last_val);

   // R4
   kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> cnt_q == '0);

   // R5
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> cnt_q == '0);

   // R6
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> cnt_q == '0);

endmodule

// File: rtl/sysopt_rst_ctl.sv
module sysopt_rst_ctl
   import sysopt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wdog_expire_i,
   input  logic       stop_req_i,
   input  logic       stop_en_i,
   output logic       fire_o,
   output logic       sys_rst_o,
   output rst_cause_e cause_o,
   output logic       stop_grant_o
);

   logic       rst_q;
   rst_cause_e cause_q;
   logic       grant_q;
   logic       illegal_stop;

   assign illegal_stop = stop_req_i && !stop_en_i;
   // no new request in the cycle a request is already out
   assign fire_o = !rst_q && (wdog_expire_i || illegal_stop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q   <= 1'b0;
         cause_q <= CAUSE_NONE;
         grant_q <= 1'b0;
      end else begin
         rst_q   <= fire_o;
         if (!fire_o)           cause_q <= CAUSE_NONE;
         else if (wdog_expire_i) cause_q <= CAUSE_WDOG;
         else                    cause_q <= CAUSE_STOP;
         grant_q <= !rst_q && !fire_o && stop_req_i && stop_en_i;
      end
   end

   assign sys_rst_o    = rst_q;
   assign cause_o      = cause_q;
   assign stop_grant_o = grant_q;

   // R8
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |=> !sys_rst_o);

   // R8
   cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_rst_o |-> cause_o == CAUSE_NONE);

   // R8
   wdog_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_expire_i && !sys_rst_o |=> sys_rst_o && cause_o == CAUSE_WDOG);

   // R7
   stop_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req_i && !stop_en_i && !sys_rst_o |=> sys_rst_o);

   // R7
   grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stop_grant_o && sys_rst_o));

endmodule

// File: rtl/sysopt_wdog_top.sv
module sysopt_wdog_top
   import sysopt_pkg::*;
#(
   parameter int SHORT_LOG2 = 18,
   parameter int LONG_LOG2  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [OPT_W-1:0] wr_data_i,
   output logic [OPT_W-1:0] rd_data_o,
   input  logic             wdog_kick_i,
   input  logic             stop_req_i,
   output logic             stop_grant_o,
   output logic             sys_rst_o,
   output logic [1:0]       rst_cause_o,
   output logic             dbg_pin_fn_o,
   output logic             rst_pin_fn_o
);

   logic [OPT_W-1:0] opt_val;
   logic             sel_restart;
   logic             wdog_expire;
   logic             fire;
   rst_cause_e       cause;

   sysopt_optreg #(
      .REG_W   (OPT_W),
      .RST_VAL (OPT_RESET),
      .WR_MASK (OPT_WMASK),
      .SEL_BIT (BIT_LONG_SEL)
   ) u_optreg (
      .clk           (clk),
      .rst_n         (rst_n),
      .soft_clr_i    (fire),
      .wr_en_i       (wr_en_i),
      .wr_data_i     (wr_data_i),
      .val_o         (opt_val),
      .sel_restart_o (sel_restart)
   );

   sysopt_wdog_cnt #(
      .SHORT_LOG2 (SHORT_LOG2),
      .LONG_LOG2  (LONG_LOG2)
   ) u_wdog (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (opt_val[BIT_WDOG_EN]),
      .long_sel_i (opt_val[BIT_LONG_SEL]),
      .kick_i     (wdog_kick_i),
      .restart_i  (sel_restart),
      .clr_i      (fire),
      .expire_o   (wdog_expire)
   );

   sysopt_rst_ctl u_rstctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .wdog_expire_i (wdog_expire),
      .stop_req_i    (stop_req_i),
      .stop_en_i     (opt_val[BIT_STOP_EN]),
      .fire_o        (fire),
      .sys_rst_o     (sys_rst_o),
      .cause_o       (cause),
      .stop_grant_o  (stop_grant_o)
   );

   assign rd_data_o    = opt_val;
   assign rst_cause_o  = cause;
   assign dbg_pin_fn_o = opt_val[BIT_DBG_FN];
   assign rst_pin_fn_o = opt_val[BIT_RST_FN];

   // R10
   pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_pin_fn_o == rd_data_o[1]) && (rst_pin_fn_o == rd_data_o[0]));

   // R1
   fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[4:2] == 3'b100);

endmodule

// File: tb/tb_sysopt_wdog_top.sv
module tb_sysopt_wdog_top;

   localparam int SHORT_LOG2 = 4;
   localparam int LONG_LOG2  = 6;
   localparam int LSHORT = 1 << SHORT_LOG2;
   localparam int LLONG  = 1 << LONG_LOG2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] rd_data_o;
   logic       wdog_kick_i = 1'b0;
   logic       stop_req_i = 1'b0;
   logic       stop_grant_o;
   logic       sys_rst_o;
   logic [1:0] rst_cause_o;
   logic       dbg_pin_fn_o;
   logic       rst_pin_fn_o;

   sysopt_wdog_top #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o), .wdog_kick_i(wdog_kick_i), .stop_req_i(stop_req_i),
      .stop_grant_o(stop_grant_o), .sys_rst_o(sys_rst_o), .rst_cause_o(rst_cause_o),
      .dbg_pin_fn_o(dbg_pin_fn_o), .rst_pin_fn_o(rst_pin_fn_o)
   );

   always #4 clk = ~clk;   // 125 MHz

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic        grant;
      logic [1:0]  cause;
      int unsigned at;
      string       tag;
   } evt_t;
   evt_t exp_q[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic g, input logic [1:0] c, input int unsigned at, input string tag);
      evt_t e;
      e.grant = g; e.cause = c; e.at = at; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wr(input logic [7:0] d);
      wr_en_i = 1'b1; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0; wr_data_i = '0;
   endtask

   task automatic wait_to(input int unsigned target);
      while (cyc < target) @(negedge clk);
   endtask

   // monitor: pops expected events as the design produces them
   always begin
      @(posedge clk); #2;
      if (rst_n && (sys_rst_o || stop_grant_o)) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 unexpected event actual=rst%0b/grant%0b cause=%0b at %0d expected=none",
                     sys_rst_o, stop_grant_o, rst_cause_o, cyc);
         end else begin
            evt_t e;
            e = exp_q.pop_front();
            chk({e.tag, " grant"}, {31'd0, stop_grant_o}, {31'd0, e.grant});
            chk({e.tag, " reset"}, {31'd0, sys_rst_o}, {31'd0, !e.grant});
            chk({e.tag, " cause"}, {30'd0, rst_cause_o}, {30'd0, e.cause});
            chk({e.tag, " cycle"}, cyc, e.at);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned c0;
      int unsigned c;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 read", {24'd0, rd_data_o}, 32'hD3);
      chk("R10 pins", {30'd0, dbg_pin_fn_o, rst_pin_fn_o}, 32'h3);
      chk("R8 idle cause", {30'd0, rst_cause_o}, 32'h0);
      rst_n = 1'b1;
      c0 = cyc;
      // R3 long timeout; R5 same-select write must not restart
      push(1'b0, 2'b01, c0 + LLONG, "R5 R3 long timeout");
      wait_to(c0 + 10);
      wr(8'hC2);
      chk("R2 first write", {24'd0, rd_data_o}, 32'hD2);
      chk("R10 reset pin", {31'd0, rst_pin_fn_o}, 32'h0);
      wait_to(c0 + LLONG + 1);
      c0 = c0 + LLONG;
      // R9 defaults back after the timeout request
      chk("R9 defaults", {24'd0, rd_data_o}, 32'hD3);
      wr(8'h00);
      chk("R2 disable write", {24'd0, rd_data_o}, 32'h10);
      wr(8'hFF);
      chk("R2 locked", {24'd0, rd_data_o}, 32'h10);
      // R6 watchdog off: no request for longer than any limit
      repeat (2 * LLONG) @(negedge clk);
      chk("R6 no timeout", {31'd0, sys_rst_o}, 32'h0);
      // R7 illegal STOP
      c = cyc;
      stop_req_i = 1'b1;
      push(1'b0, 2'b10, c + 1, "R7 illegal stop");
      @(negedge clk);
      stop_req_i = 1'b0;
      c0 = c + 1;
      chk("R9 defaults after stop trap", {24'd0, rd_data_o}, 32'hD3);
      // short timeout, stop allowed, pins to port mode; select change restarts
      c = cyc;
      wr(8'hA0);
      c0 = c + 1;
      chk("R2 short write", {24'd0, rd_data_o}, 32'hB0);
      chk("R10 pins port", {30'd0, dbg_pin_fn_o, rst_pin_fn_o}, 32'h0);
      wait_to(c0 + 2);
      stop_req_i = 1'b1;
      push(1'b1, 2'b00, c0 + 3, "R7 stop grant");
      @(negedge clk);
      stop_req_i = 1'b0;
      // R4 kick in the final cycle
      wait_to(c0 + LSHORT - 1);
      wdog_kick_i = 1'b1;
      @(negedge clk);
      wdog_kick_i = 1'b0;
      c0 = c0 + LSHORT;
      wait_to(c0 + 8);
      wdog_kick_i = 1'b1;
      @(negedge clk);
      wdog_kick_i = 1'b0;
      c0 = c0 + 9;
      push(1'b0, 2'b01, c0 + LSHORT, "R4 R3 short timeout");
      wait_to(c0 + LSHORT + 1);
      c0 = c0 + LSHORT;
      chk("R9 pins restored", {30'd0, dbg_pin_fn_o, rst_pin_fn_o}, 32'h3);
      // R8 timeout and illegal STOP in the same cycle
      wait_to(c0 + LLONG - 1);
      stop_req_i = 1'b1;
      push(1'b0, 2'b01, c0 + LLONG, "R8 priority");
      @(negedge clk);
      stop_req_i = 1'b0;
      @(negedge clk);
      wr(8'h00);
      repeat (20) @(negedge clk);
      chk("R8 all expected events seen", exp_q.size(), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule